// File: doc/BRIEF.md
# Synchronous Serial Receive Start and Clock Controller

This block sits on the receive side of a synchronous serial port. It selects one of three receive clock sources and brings the chosen clock, the frame-sync line and the serial data line into the system clock domain through a synchronizer. The edges of the synchronized clock become one-cycle strobes. The sample strobe marks the edge on which data and frame sync are captured. The shift strobe marks the opposite edge, on which a frame-sync output would change. An inversion bit swaps which edge plays which role. An optional gate suppresses both strobes while the frame-sync level is the wrong one.

A small state machine decides when a receive word starts. It has three states. `ST_OFF` is the disabled state. `ST_HUNT` waits for the start condition. `ST_RECV` holds `rx_active` high for a programmed number of sample strobes. Its transitions are:

- T_ENABLE: `ST_OFF` to `ST_HUNT`, when the receiver is enabled.
- T_START: `ST_HUNT` to `ST_RECV`, when the selected start condition is met.
- T_WORD_DONE: `ST_RECV` to `ST_HUNT`, after the last sample strobe of a word.
- T_RELOAD: `ST_RECV` to `ST_RECV` with the count reloaded, after the last sample strobe in continuous mode.
- T_DISABLE: any state to `ST_OFF`, when the enable is cleared.

The start condition is chosen from nine options:

- continuous reception;
- a pulse from the transmitter;
- a frame-sync level, an edge or any change of frame sync;
- a match of the incoming bits against a programmable pattern.

The block also produces the output enable for the receive clock pin. The clock it drives out is never inverted.

Top module: `rxs_ctrl`

## Requirements
- R1: `cfg_clk_src` selects the clock that produces the strobes: 0 selects `div_clk`, 1 selects `tx_clk`, 2 selects `pin_clk_in`, and the reserved value 3 behaves like 0. Toggling a clock input that is not selected produces no strobe.
- R2: Each selected clock edge gives a strobe that is exactly one system cycle long and appears two system cycles after the edge reaches the input. With `cfg_inv`=0, `sample_stb` follows falling edges and `shift_stb` follows rising edges. With `cfg_inv`=1 the roles are swapped. Frame sync and data are captured at the sample strobe.
- R3: `cfg_gate` controls gating of both strobes. With 0 the strobes are never gated. With 1 they appear only while the synchronized frame sync is low. With 2 they appear only while it is high. The reserved value 3 behaves like 0.
- R4: `cfg_start` 0 (continuous) starts a word as soon as the block is enabled. `cfg_start` 1 starts a word on a `tx_start` pulse seen in `ST_HUNT`. In every other mode `tx_start` is ignored. The reserved values 9 to 15 behave like 0.
- R5: `cfg_start` 2 starts at a sample strobe that sees frame sync low. `cfg_start` 3 starts at a sample strobe that sees frame sync high. Levels are evaluated only in `ST_HUNT`.
- R6: Edge starts compare the frame sync captured at this sample strobe with the one captured at the previous sample strobe. That previous value is 0 after reset. `cfg_start` 4 starts on a 1-to-0 change and 5 on a 0-to-1 change. Both 6 and 7 start on any difference.
- R7: `cfg_start` 8 starts when the low `cmp_len` bits of the received bit history equal the same bits of `cmp_pattern`. The history shifts one bit per sample strobe, with the newest bit entering at bit 0. Valid lengths are 1 to 16.
- R8: After a start, `rx_active` stays high for exactly `data_len` sample strobes. The strobe that caused the start is not counted. The block then returns to `ST_HUNT`, or reloads and stays active in continuous mode. A `data_len` of 0 counts as 1.
- R9: Clearing `rx_en` drops `rx_active` after one system clock edge. No start condition is acted on while `rx_en` is low.
- R10: `cfg_out_mode` controls `pin_clk_oe`. With 0 the pin is never driven. With 1 it is always driven. With 2 it is driven only while `rx_active` is high. The reserved value 3 behaves like 0.
- R11: `pin_clk_out` is the synchronized selected clock, delayed two system cycles, whatever the value of `cfg_inv`.
- R12: `cfg_error` sets when any configuration field holds a reserved value and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| cfg_clk_src | input | 2 | Receive clock source select |
| cfg_start | input | 4 | Start condition select |
| cfg_gate | input | 2 | Frame-sync clock gating select |
| cfg_inv | input | 1 | Sampling edge inversion |
| cfg_out_mode | input | 2 | Receive clock pin drive mode |
| cmp_pattern | input | CMP_W | Compare pattern for pattern start |
| cmp_len | input | $clog2(CMP_W+1) | Number of compared bits |
| data_len | input | LEN_W | Sample strobes per word |
| div_clk | input | 1 | Internally divided clock |
| tx_clk | input | 1 | Transmit clock |
| pin_clk_in | input | 1 | Receive clock pin input |
| fsync_in | input | 1 | Receive frame sync |
| data_in | input | 1 | Receive serial data |
| tx_start | input | 1 | Transmitter start pulse |
| sample_stb | output | 1 | One-cycle sample strobe |
| shift_stb | output | 1 | One-cycle shift strobe |
| rx_active | output | 1 | Word reception in progress |
| pin_clk_oe | output | 1 | Receive clock pin output enable |
| pin_clk_out | output | 1 | Receive clock pin output value |
| cfg_error | output | 1 | Sticky reserved-configuration flag |

## Verification
The bench sweeps every pair of clock source and toggled clock line, so a multiplexer that routes the wrong input, or treats reserved source 3 as the pin, shows wrong strobe counts. It runs all sixteen start codes against one fixed frame-sync and data sequence and compares the number of starts and active strobes with a behavioural model. An edge detector that compares against the previous system cycle instead of the previous sample strobe would miss starts. So would a comparator that shifts on the wrong bit end, a continuous mode that idles between words, or an off-by-one word length. Each gating value is swept over a mixed frame-sync pattern. The bench also checks the strobe phase against the clock edge for both inversion settings and checks that the pin copy never inverts. It checks that `tx_start` and frame-sync edges are ignored while disabled, which a design that keeps hunting during disable would fail.

// File: rtl/rxs_pkg.sv
`timescale 1ns/1ps
package rxs_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_RECV = 2'd2
    } rx_state_t;

    typedef enum logic [3:0] {
        SC_CONT    = 4'd0,
        SC_TX      = 4'd1,
        SC_FS_LOW  = 4'd2,
        SC_FS_HIGH = 4'd3,
        SC_FS_FALL = 4'd4,
        SC_FS_RISE = 4'd5,
        SC_FS_CHG  = 4'd6,
        SC_FS_EDGE = 4'd7,
        SC_CMP     = 4'd8
    } start_code_t;

    localparam logic [1:0] SRC_DIV  = 2'd0;
    localparam logic [1:0] SRC_TX   = 2'd1;
    localparam logic [1:0] SRC_PIN  = 2'd2;
    localparam logic [1:0] GATE_LOW  = 2'd1;
    localparam logic [1:0] GATE_HIGH = 2'd2;
    localparam logic [1:0] OUT_ALWAYS = 2'd1;
    localparam logic [1:0] OUT_XFER   = 2'd2;
    localparam logic [1:0] FIELD_RSVD = 2'd3;
    localparam logic [3:0] SC_LAST    = 4'd8;

endpackage

// File: rtl/rxs_clk_sel.sv
`timescale 1ns/1ps
module rxs_clk_sel
    import rxs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic [1:0] gate,
    input  logic       inv,
    input  logic       div_clk,
    input  logic       tx_clk,
    input  logic       pin_clk,
    input  logic       fs_raw,
    input  logic       d_raw,
    output logic       samp_stb,
    output logic       shft_stb,
    output logic       fs_now,
    output logic       d_now,
    output logic       clk_sync
);
    localparam int LAST = SYNC_STAGES - 1;

    logic       raw_clk;
    logic [2:0] pipe [SYNC_STAGES];
    logic       clk_prev;
    logic       rise, fall, gate_ok;

    always_comb begin
        unique case (src)
            SRC_TX:  raw_clk = tx_clk;
            SRC_PIN: raw_clk = pin_clk;
            default: raw_clk = div_clk;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) pipe[k] <= '0;
            clk_prev <= 1'b0;
        end else begin
            pipe[0] <= {raw_clk, fs_raw, d_raw};
            for (int k = 1; k < SYNC_STAGES; k++) pipe[k] <= pipe[k-1];
            clk_prev <= pipe[LAST][2];
        end
    end

    assign clk_sync = pipe[LAST][2];
    assign fs_now   = pipe[LAST][1];
    assign d_now    = pipe[LAST][0];
    assign rise     = clk_sync & ~clk_prev;
    assign fall     = ~clk_sync & clk_prev;

    always_comb begin
        unique case (gate)
            GATE_LOW:  gate_ok = ~fs_now;
            GATE_HIGH: gate_ok = fs_now;
            default:   gate_ok = 1'b1;
        endcase
    end

    assign samp_stb = gate_ok & (inv ? rise : fall);
    assign shft_stb = gate_ok & (inv ? fall : rise);
endmodule

// File: rtl/rxs_start_det.sv
`timescale 1ns/1ps
module rxs_start_det
    import rxs_pkg::*;
#(
    parameter int CMP_W  = 16,
    parameter int CLEN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        code,
    input  logic              samp_stb,
    input  logic              fs_now,
    input  logic              d_now,
    input  logic              tx_start,
    input  logic [CMP_W-1:0]  cmp_pat,
    input  logic [CLEN_W-1:0] cmp_len,
    output logic              hit,
    output logic              cont,
    output logic              code_bad
);
    logic             fs_last;
    logic [CMP_W-1:0] hist_q, hist_nx, mask;
    logic             match;

    assign hist_nx = {hist_q[CMP_W-2:0], d_now};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_last <= 1'b0;
            hist_q  <= '0;
        end else if (samp_stb) begin
            fs_last <= fs_now;
            hist_q  <= hist_nx;
        end
    end

    always_comb begin
        for (int j = 0; j < CMP_W; j++) mask[j] = (32'(j) < 32'(cmp_len));
    end

    assign match    = ((hist_nx ^ cmp_pat) & mask) == '0;
    assign code_bad = code > SC_LAST;
    assign cont     = (code == SC_CONT) || code_bad;

    always_comb begin
        if (code_bad) hit = 1'b1;
        else begin
            unique case (start_code_t'(code))
                SC_CONT:    hit = 1'b1;
                SC_TX:      hit = tx_start;
                SC_FS_LOW:  hit = samp_stb & ~fs_now;
                SC_FS_HIGH: hit = samp_stb & fs_now;
                SC_FS_FALL: hit = samp_stb & fs_last & ~fs_now;
                SC_FS_RISE: hit = samp_stb & ~fs_last & fs_now;
                SC_FS_CHG,
                SC_FS_EDGE: hit = samp_stb & (fs_last ^ fs_now);
                SC_CMP:     hit = samp_stb & match;
                default:    hit = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/rxs_ctrl.sv
`timescale 1ns/1ps
module rxs_ctrl
    import rxs_pkg::*;
#(
    parameter int CMP_W       = 16,
    parameter int LEN_W       = 6,
    parameter int SYNC_STAGES = 2,
    localparam int CLEN_W     = $clog2(CMP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [1:0]        cfg_clk_src,
    input  logic [3:0]        cfg_start,
    input  logic [1:0]        cfg_gate,
    input  logic              cfg_inv,
    input  logic [1:0]        cfg_out_mode,
    input  logic [CMP_W-1:0]  cmp_pattern,
    input  logic [CLEN_W-1:0] cmp_len,
    input  logic [LEN_W-1:0]  data_len,
    input  logic              div_clk,
    input  logic              tx_clk,
    input  logic              pin_clk_in,
    input  logic              fsync_in,
    input  logic              data_in,
    input  logic              tx_start,
    output logic              sample_stb,
    output logic              shift_stb,
    output logic              rx_active,
    output logic              pin_clk_oe,
    output logic              pin_clk_out,
    output logic              cfg_error
);
    rx_state_t        st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d, word_len;
    logic             fs_now, d_now, clk_sync;
    logic             start_hit, cont, code_bad, cfg_bad, err_q;

    rxs_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk(clk), .rst_n(rst_n), .src(cfg_clk_src), .gate(cfg_gate),
        .inv(cfg_inv), .div_clk(div_clk), .tx_clk(tx_clk),
        .pin_clk(pin_clk_in), .fs_raw(fsync_in), .d_raw(data_in),
        .samp_stb(sample_stb), .shft_stb(shift_stb), .fs_now(fs_now),
        .d_now(d_now), .clk_sync(clk_sync)
    );

    rxs_start_det #(.CMP_W(CMP_W), .CLEN_W(CLEN_W)) u_start (
        .clk(clk), .rst_n(rst_n), .code(cfg_start), .samp_stb(sample_stb),
        .fs_now(fs_now), .d_now(d_now), .tx_start(tx_start),
        .cmp_pat(cmp_pattern), .cmp_len(cmp_len), .hit(start_hit),
        .cont(cont), .code_bad(code_bad)
    );

    assign word_len = (data_len == '0) ? LEN_W'(1) : data_len;

    // Next state: T_DISABLE, T_ENABLE, T_START, T_WORD_DONE, T_RELOAD
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!rx_en) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:  st_d = ST_HUNT;
                ST_HUNT: if (start_hit) begin
                    st_d  = ST_RECV;
                    cnt_d = word_len;
                end
                ST_RECV: if (sample_stb) begin
                    if (cnt_q == LEN_W'(1)) begin
                        cnt_d = word_len;
                        st_d  = cont ? ST_RECV : ST_HUNT;
                    end else begin
                        cnt_d = cnt_q - LEN_W'(1);
                    end
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (cfg_bad) err_q <= 1'b1;
        end
    end

    assign cfg_bad = code_bad || (cfg_clk_src == FIELD_RSVD) ||
                     (cfg_gate == FIELD_RSVD) || (cfg_out_mode == FIELD_RSVD);

    // Outputs
    always_comb begin
        rx_active   = (st_q == ST_RECV);
        pin_clk_oe  = (cfg_out_mode == OUT_ALWAYS) ||
                      ((cfg_out_mode == OUT_XFER) && (st_q == ST_RECV));
        pin_clk_out = clk_sync;
        cfg_error   = err_q;
    end
endmodule

// File: rtl/rxs_ctrl_chk.sv
`timescale 1ns/1ps
module rxs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic [1:0] cfg_out_mode,
    input logic       sample_stb,
    input logic       shift_stb,
    input logic       rx_active,
    input logic       pin_clk_oe,
    input logic       cfg_error
);
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb)); // R2
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R2
    AST_WORD_END_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_active) && $past(rx_en)) |-> $past(sample_stb)); // R8
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_active); // R9
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> $past(rx_en)); // R9
    AST_OE_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_clk_oe && !rx_active) |-> (cfg_out_mode == 2'd1)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error); // R12
endmodule

bind rxs_ctrl rxs_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_out_mode(cfg_out_mode),
    .sample_stb(sample_stb), .shift_stb(shift_stb), .rx_active(rx_active),
    .pin_clk_oe(pin_clk_oe), .cfg_error(cfg_error)
);

// File: tb/rxs_ctrl_test.sv
`timescale 1ns/1ps
module rxs_ctrl_test;
    localparam logic [15:0] FS_PAT = 16'b1000_1101_0001_1100;
    localparam logic [15:0] DT_PAT = 16'h2D36;
    localparam logic [15:0] CMP_P  = 16'h000B;

    logic clk = 0, rst_n = 0, rx_en = 0, cfg_inv = 0;
    logic [1:0] cfg_clk_src = 0, cfg_gate = 0, cfg_out_mode = 0;
    logic [3:0] cfg_start = 0;
    logic [15:0] cmp_pattern = CMP_P;
    logic [4:0] cmp_len = 5'd4;
    logic [5:0] data_len = 6'd3;
    logic div_clk = 0, tx_clk = 0, pin_clk_in = 0, fsync_in = 0, data_in = 0, tx_start = 0;
    logic sample_stb, shift_stb, rx_active, pin_clk_oe, pin_clk_out, cfg_error;

    rxs_ctrl uut (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    int drv_sel = 2;
    logic cur = 0;
    int last_rise = 0, last_fall = 0;
    int n_samp, n_shift, n_act, n_starts, n_phase_bad, n_pin_bad;
    logic act_q;
    logic [2:0] hist;
    logic chk_pin = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_stb) begin
                n_samp++;
                if (rx_active) n_act++;
                if (cyc != (cfg_inv ? last_rise : last_fall) + 2) n_phase_bad++;
            end
            if (shift_stb) begin
                n_shift++;
                if (cyc != (cfg_inv ? last_fall : last_rise) + 2) n_phase_bad++;
            end
            if (rx_active && !act_q) n_starts++;
            act_q = rx_active;
            hist = {hist[1:0], cur};
            if (chk_pin && pin_clk_out !== hist[2]) n_pin_bad++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clr();
        n_samp = 0; n_shift = 0; n_act = 0; n_starts = 0;
        n_phase_bad = 0; n_pin_bad = 0; act_q = 0; hist = {3{cur}};
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_clk(logic v);
        if (v && !cur) last_rise = cyc;
        if (!v && cur) last_fall = cyc;
        cur = v;
        case (drv_sel)
            0: div_clk = v;
            1: tx_clk = v;
            default: pin_clk_in = v;
        endcase
    endtask

    task automatic bit_period(logic f, logic d, logic txp);
        set_clk(0); tick(2);
        fsync_in = f; data_in = d; tick(2);
        set_clk(1); tick(1);
        tx_start = txp; tick(1);
        tx_start = 0; tick(2);
    endtask

    task automatic tail();
        set_clk(0); tick(6);
    endtask

    task automatic do_reset();
        rx_en = 0; rst_n = 0;
        cfg_clk_src = 2; cfg_start = 0; cfg_gate = 0; cfg_inv = 0; cfg_out_mode = 0;
        data_len = 3; drv_sel = 2;
        div_clk = 0; tx_clk = 0; pin_clk_in = 0; cur = 0; fsync_in = 0; data_in = 0;
        tick(2); rst_n = 1; tick(1);
    endtask

    // Behavioural start model built from R4..R8
    task automatic model(int code, int len, int txk, output int act, output int starts);
        logic busy, cont, f, d, prevf, hit;
        int cnt;
        logic [15:0] sr;
        cont = (code == 0) || (code > 8);
        busy = 0; cnt = 0; prevf = 0; sr = 0; act = 0; starts = 0;
        if (cont) begin busy = 1; cnt = len; starts = 1; end
        for (int i = 0; i < 16; i++) begin
            f = FS_PAT[i]; d = DT_PAT[i];
            if (!busy && code == 1 && i == txk) begin busy = 1; cnt = len; starts++; end
            sr = {sr[14:0], d};
            if (busy) begin
                act++;
                if (cnt == 1) begin
                    if (cont) cnt = len; else busy = 0;
                end else cnt--;
            end else begin
                case (code)
                    2: hit = !f;
                    3: hit = f;
                    4: hit = prevf && !f;
                    5: hit = !prevf && f;
                    6, 7: hit = prevf != f;
                    8: hit = (sr[3:0] == CMP_P[3:0]);
                    default: hit = 0;
                endcase
                if (hit) begin busy = 1; cnt = len; starts++; end
            end
            prevf = f;
        end
    endtask

    task automatic run_start(int code, int len);
        int ea, es;
        do_reset();
        cfg_start = 4'(code); data_len = 6'(len);
        rx_en = 1; tick(3); clr();
        for (int i = 0; i < 16; i++) bit_period(FS_PAT[i], DT_PAT[i], i == 2);
        tail();
        model(code, len, 2, ea, es);
        chk(code == 8 ? "R7" : (code >= 4 && code <= 7) ? "R6" : (code == 2 || code == 3) ? "R5" : "R4",
            $sformatf("starts code=%0d len=%0d", code, len), n_starts, es);
        chk("R8", $sformatf("active strobes code=%0d len=%0d", code, len), n_act, ea);
        chk("R12", $sformatf("cfg_error start code=%0d", code), int'(cfg_error), int'(code > 8));
        rx_en = 0; tick(1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R9", "reset rx_active", int'(rx_active), 0);
        chk("R10", "reset pin_clk_oe", int'(pin_clk_oe), 0);
        chk("R12", "reset cfg_error", int'(cfg_error), 0);
        chk("R2", "reset strobes", int'(sample_stb | shift_stb), 0);

        // R1: every source value against every toggled line
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 3; d++) begin
                do_reset();
                cfg_clk_src = 2'(s); drv_sel = d; cfg_start = 1;
                rx_en = 1; tick(3); clr();
                for (int i = 0; i < 4; i++) bit_period(0, 0, 0);
                tail();
                chk("R1", $sformatf("strobes src=%0d line=%0d", s, d), n_samp,
                    (d == ((s == 3) ? 0 : s)) ? 4 : 0);
            end
            chk("R12", $sformatf("cfg_error src=%0d", s), int'(cfg_error), int'(s == 3));
        end

        // R2, R11: inversion and the pin copy
        for (int v = 0; v < 2; v++) begin
            do_reset();
            cfg_inv = v[0]; cfg_start = 1; rx_en = 1; tick(3); clr(); chk_pin = 1;
            for (int i = 0; i < 6; i++) bit_period(1'(i & 1), 0, 0);
            tail(); chk_pin = 0;
            chk("R2", $sformatf("sample count inv=%0d", v), n_samp, 6);
            chk("R2", $sformatf("shift count inv=%0d", v), n_shift, 6);
            chk("R2", $sformatf("strobe phase errors inv=%0d", v), n_phase_bad, 0);
            chk("R11", $sformatf("pin copy mismatches inv=%0d", v), n_pin_bad, 0);
        end

        // R3: gating sweep over a mixed frame-sync pattern
        for (int g = 0; g < 4; g++) begin
            int lows, exp_n;
            do_reset();
            cfg_gate = 2'(g); cfg_start = 1; rx_en = 1; tick(3); clr();
            lows = 0;
            for (int i = 0; i < 8; i++) begin
                bit_period(FS_PAT[i], 0, 0);
                if (!FS_PAT[i]) lows++;
            end
            tail();
            exp_n = (g == 1) ? lows : (g == 2) ? 8 - lows : 8;
            chk("R3", $sformatf("gated sample count gate=%0d", g), n_samp, exp_n);
            chk("R3", $sformatf("gated shift count gate=%0d", g), n_shift, exp_n);
            chk("R12", $sformatf("cfg_error gate=%0d", g), int'(cfg_error), int'(g == 3));
        end

        // R4..R8, R12: all start codes, then word lengths
        for (int c = 0; c < 16; c++) run_start(c, 3);
        run_start(0, 1); run_start(0, 5); run_start(4, 1); run_start(5, 2); run_start(8, 5);

        // R9: disable drops rx_active; starts ignored while disabled
        do_reset();
        rx_en = 1; tick(3);
        bit_period(0, 0, 0); bit_period(1, 0, 0);
        chk("R4", "continuous active after enable", int'(rx_active), 1);
        rx_en = 0; tick(1);
        chk("R9", "rx_active one clock after disable", int'(rx_active), 0);
        cfg_start = 5; clr();
        for (int i = 0; i < 6; i++) bit_period(1'(i & 1), 0, 0);
        tail();
        chk("R9", "frame-sync starts while disabled", n_starts, 0);
        cfg_start = 1; clr();
        tx_start = 1; tick(1); tx_start = 0; tick(2);
        chk("R9", "tx start while disabled", n_starts, 0);

        // R10: pin output enable modes
        for (int m = 0; m < 4; m++) begin
            do_reset();
            cfg_out_mode = 2'(m); cfg_start = 1; rx_en = 1; tick(3);
            chk("R10", $sformatf("oe idle mode=%0d", m), int'(pin_clk_oe), int'(m == 1));
            tx_start = 1; tick(1); tx_start = 0; tick(1);
            chk("R4", $sformatf("tx start mode=%0d", m), int'(rx_active), 1);
            chk("R10", $sformatf("oe active mode=%0d", m), int'(pin_clk_oe), int'(m == 1 || m == 2));
            chk("R12", $sformatf("cfg_error out mode=%0d", m), int'(cfg_error), int'(m == 3));
        end

        finish_run();
    end
endmodule